// File: doc/BRIEF.md
# Paired-Bit Set/Clear GPIO Bank

This block drives eight general-purpose pins from one 32-bit command word. Software never has to read, modify and write back a data field: every pin owns four write-one command bits. Two of them move the pin's output latch low or high. The other two switch the pin between input and output. Writing a 0 to any command bit changes nothing, so one write can touch any subset of pins without disturbing the others.

Each pin keeps a direction state machine with two states, `DIR_IN` and `DIR_OUT`, and a separate output latch. The transition `go_out` leaves `DIR_IN` when the pin's ENABLE bit is written and its DISABLE bit is not. The transition `go_in` leaves `DIR_OUT` when the pin's DISABLE bit is written. In every other case the pin holds its state.

The pin inputs pass through a two-flop synchroniser. The readback word is always present on `rd_data`. Its lower half shows either the driven level or the sampled level of each pin, depending on the pin's direction. Its upper half shows the direction of each pin as a complementary pair. To toggle a pin, software reads bit 2n and then writes CLEAR if that bit read 1, or SET if it read 0.

Top module: `gpio_pair_bank`

## Requirements
- R1: After reset every pin is in `DIR_IN` with `pin_oe` at 0, and every output latch and `pin_out` is 0.
- R2: A write with bit 2n+1 (SET) at 1 makes `pin_out[n]` 1 from the next clock edge.
- R3: A write with bit 2n (CLEAR) at 1 and bit 2n+1 at 0 makes `pin_out[n]` 0 from the next clock edge.
- R4: A write with bit 16+2n (ENABLE) at 1 and bit 17+2n at 0 makes pin n an output, so `pin_oe[n]` is 1 from the next clock edge.
- R5: A write with bit 17+2n (DISABLE) at 1 makes pin n an input, so `pin_oe[n]` is 0 from the next clock edge.
- R6: A command bit written as 0 has no effect on its pin. While `wr_en` is 0, no latch and no direction changes.
- R7: When both bits of a pair are 1 in one write, the later one wins: SET over CLEAR, and DISABLE over ENABLE.
- R8: Readback bit 2n equals the output latch of pin n while the pin is an output, and reads 0 while it is an input.
- R9: Readback bit 2n+1 equals the synchronised level of `pin_in[n]` while pin n is an input, and reads 0 while it is an output. A change on `pin_in` first appears there after two clock edges.
- R10: Readback bit 16+2n equals the direction of pin n (1 = output), and bit 17+2n is its inverse.
- R11: Every pin follows only its own four command bits. `pin_out[n]` always shows the latch and `pin_oe[n]` always shows the direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word: data pairs in bits 15:0, direction pairs in bits 31:16 |
| rd_data | output | 32 | Status readback word |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output data per pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
The assertions assume that `wr_data` is stable and known whenever `wr_en` is 1, and that `pin_in` may change at any time. The readback checks assume that a pin level has been held for at least two edges. The bench drives every input on the falling edge. Before any write that is checked against a sampled level, it changes `pin_in` and then waits two full cycles. Only the dedicated latency test changes `pin_in` and samples one and two edges later. The sweep covers all sixteen command nibbles from every starting state of every pin, while random commands go to the other pins at the same time.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } pin_dir_e;

    // Per-pin command nibble gathered from the command word
    typedef struct packed {
        logic dis;
        logic en;
        logic set;
        logic clr;
    } pin_cmd_t;

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpb_pin_cell.sv
module gpb_pin_cell
    import gpb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  pin_cmd_t cmd,
    output logic     out_q,
    output logic     oe
);
    pin_dir_e dir_q, dir_d;

    // Direction state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= DIR_IN;
        else        dir_q <= dir_d;
    end

    // Next-state: go_out / go_in; DISABLE dominates ENABLE
    always_comb begin
        dir_d = dir_q;
        if (wr_en) begin
            unique case (dir_q)
                DIR_IN:  if (cmd.en && !cmd.dis) dir_d = DIR_OUT;
                DIR_OUT: if (cmd.dis)            dir_d = DIR_IN;
            endcase
        end
    end

    // Output latch; SET dominates CLEAR
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (wr_en) begin
            if (cmd.set)      out_q <= 1'b1;
            else if (cmd.clr) out_q <= 1'b0;
        end
    end

    // Output process
    always_comb begin
        unique case (dir_q)
            DIR_IN:  oe = 1'b0;
            DIR_OUT: oe = 1'b1;
        endcase
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.set) |=> out_q);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.clr && !cmd.set) |=> !out_q);
    p_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.en && !cmd.dis) |=> oe);
    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.dis) |=> !oe);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(out_q) && $stable(oe)));
    p_zero_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd == '0) |=> ($stable(out_q) && $stable(oe)));

endmodule

// File: rtl/gpb_readback.sv
module gpb_readback #(
    parameter int NUM_PINS = 8,
    localparam int HALF_W = 2*NUM_PINS,
    localparam int REG_W  = 2*HALF_W
) (
    input  logic [NUM_PINS-1:0] lat,
    input  logic [NUM_PINS-1:0] oe,
    input  logic [NUM_PINS-1:0] lvl,
    output logic [REG_W-1:0]    word
);
    generate
        for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
            assign word[2*n]          = oe[n] ? lat[n] : 1'b0;
            assign word[2*n+1]        = oe[n] ? 1'b0   : lvl[n];
            assign word[HALF_W+2*n]   = oe[n];
            assign word[HALF_W+2*n+1] = ~oe[n];
        end
    endgenerate

endmodule

// File: rtl/gpio_pair_bank.sv
module gpio_pair_bank
    import gpb_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int HALF_W = 2*NUM_PINS,
    localparam int REG_W  = 2*HALF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    logic [NUM_PINS-1:0] lvl_sync;

    gpb_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl_sync)
    );

    generate
        for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
            pin_cmd_t cmd;
            assign cmd.clr = wr_data[2*n];
            assign cmd.set = wr_data[2*n+1];
            assign cmd.en  = wr_data[HALF_W+2*n];
            assign cmd.dis = wr_data[HALF_W+2*n+1];

            gpb_pin_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (wr_en),
                .cmd   (cmd),
                .out_q (pin_out[n]),
                .oe    (pin_oe[n])
            );

            p_dir_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_data[HALF_W+2*n] == pin_oe[n]) && (rd_data[HALF_W+2*n+1] == !pin_oe[n]));
            p_lat_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
                pin_oe[n] |-> (rd_data[2*n] == pin_out[n]) && !rd_data[2*n+1]);
            p_lvl_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !pin_oe[n] |-> !rd_data[2*n] && (rd_data[2*n+1] == lvl_sync[n]));
        end
    endgenerate

    gpb_readback #(.NUM_PINS(NUM_PINS)) u_rb (
        .lat  (pin_out),
        .oe   (pin_oe),
        .lvl  (lvl_sync),
        .word (rd_data)
    );

endmodule

// File: tb/tb_gpio_pair_bank.sv
module tb_gpio_pair_bank;
    localparam int NP = 8;
    localparam int RW = 4*NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [RW-1:0] wr_data = '0;
    logic [RW-1:0] rd_data;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;

    logic [NP-1:0] m_lat = '0;
    logic [NP-1:0] m_dir = '0;
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_pair_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [RW-1:0] exp_word(input logic [NP-1:0] lvl);
        logic [RW-1:0] w = '0;
        for (int n = 0; n < NP; n++) begin
            w[2*n]        = m_dir[n] & m_lat[n];
            w[2*n+1]      = ~m_dir[n] & lvl[n];
            w[2*NP+2*n]   = m_dir[n];
            w[2*NP+2*n+1] = ~m_dir[n];
        end
        return w;
    endfunction

    task automatic model(input logic [RW-1:0] w);
        for (int n = 0; n < NP; n++) begin
            if (w[2*n+1])      m_lat[n] = 1'b1;
            else if (w[2*n])   m_lat[n] = 1'b0;
            if (w[2*NP+2*n+1]) m_dir[n] = 1'b0;
            else if (w[2*NP+2*n]) m_dir[n] = 1'b1;
        end
    endtask

    task automatic check(input string tag, input logic [NP-1:0] lvl);
        logic [RW-1:0] e = exp_word(lvl);
        vectors++;
        if (rd_data !== e || pin_out !== m_lat || pin_oe !== m_dir) begin
            miscompares++;
            $display("FAIL %s: rd=%h out=%h oe=%h expected rd=%h out=%h oe=%h",
                     tag, rd_data, pin_out, pin_oe, e, m_lat, m_dir);
        end
    endtask

    task automatic do_write(input logic [RW-1:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0; wr_data = $urandom();
        model(w);
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] w;
        logic [NP-1:0] a, b;
        pin_in = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset state", pin_in);

        // R2/R4: drive all pins high as outputs
        do_write({{NP{2'b01}}, {NP{2'b10}}});
        check("R2 R4 set and enable all", pin_in);
        // R3: clear even pins only, odd pins untouched
        do_write({{NP{2'b00}}, {NP/2{4'b0001}}});
        check("R3 R6 clear even pins", pin_in);
        // R6: idle cycles, garbage on wr_data
        repeat (5) @(negedge clk);
        check("R6 no write no change", pin_in);
        // R7: both bits of every pair
        do_write({{NP{2'b11}}, {NP{2'b11}}});
        check("R7 set and disable win", pin_in);
        // R5/R9: inputs reflect synced level
        set_pins(8'h3C);
        check("R5 R9 inputs show level", pin_in);

        // R9 latency: one edge later old level, two edges later new level
        a = pin_in; b = ~a;
        @(negedge clk); pin_in = b;
        @(negedge clk); check("R9 one edge after change", a);
        @(negedge clk); check("R9 two edges after change", b);

        // Toggle sequence per requirement bit 2n readback
        do_write({{NP{2'b01}}, {NP{2'b00}}});
        for (int t = 0; t < 4; t++) begin
            w = '0;
            for (int n = 0; n < NP; n++) w[2*n + (rd_data[2*n] ? 0 : 1)] = 1'b1;
            do_write(w);
            check("R8 R11 toggle via readback", pin_in);
        end

        // Sweep: every pin, every start state, every command nibble
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < 4; s++) begin
                for (int c = 0; c < 16; c++) begin
                    logic [RW-1:0] pm;
                    pm = '0;
                    pm[2*p] = 1'b1; pm[2*p+1] = 1'b1;
                    pm[2*NP+2*p] = 1'b1; pm[2*NP+2*p+1] = 1'b1;
                    set_pins(NP'($urandom()));
                    w = ($urandom() & ~pm);
                    w[2*p + (s[0] ? 1 : 0)] = 1'b1;
                    w[2*NP + 2*p + (s[1] ? 0 : 1)] = 1'b1;
                    do_write(w);
                    check("R10 R11 sweep setup", pin_in);
                    w = ($urandom() & ~pm);
                    w[2*p]        = c[0];
                    w[2*p+1]      = c[1];
                    w[2*NP+2*p]   = c[2];
                    w[2*NP+2*p+1] = c[3];
                    do_write(w);
                    check("R2 R3 R4 R5 R6 R7 R8 R9 sweep command", pin_in);
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule